// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block supplies predicted load values for pointer-chasing code while the core runs ahead of a long cache miss. Rather than remembering the value a load returned, it remembers the difference between the load's effective address and the value it returned. For loads that read pointers out of regularly allocated structures, this difference is often the same from one execution to the next. A dependent load can then be given an address even though the pointer it needs has not yet come back from memory.

The block has two ports. On the training port it is shown each load that retires in normal mode: its PC, its effective address and the data it returned. It keeps only loads whose delta lies inside a bounded window, because a large delta suggests the value is not a pointer. On the lookup port it is shown a load that missed in L2 during runahead: its PC and its effective address. One cycle later it answers with a valid flag and a predicted value. The entries sit in a small set-associative table, and each entry holds a PC tag, the last delta seen and a saturating confidence counter. A wrong prediction needs no repair, so the lookup port has no rollback path.

Top module: `avd_predictor`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `predValid` is 0 and `predValue` is 0. After reset the table is empty, so no lookup predicts until training has taken place.
- R2: The delta of a training load is `trainAddr - trainData` in modulo 2^ADDR_W arithmetic. A prediction returns `lookupAddr - storedDelta`.
- R3: A training load whose delta, read as a signed ADDR_W-bit number, lies outside [-MAX_DELTA, +MAX_DELTA] has no effect: it allocates no entry and leaves every existing entry's delta, confidence and recency unchanged. Deltas exactly at either bound are accepted.
- R4: The set index is the low log2(NUM_SETS) bits of the PC, and the tag is the remaining upper bits. Up to NUM_WAYS different PCs that share a set are held at the same time.
- R5: A newly allocated entry starts with confidence 0. Each training whose delta equals the stored delta raises the confidence by one, saturating at 3. A prediction is made only when the confidence is 3, so the fourth consecutive matching training of a new PC is the first one that enables a prediction.
- R6: A training that hits an entry with a different delta stores the new delta and clears the confidence to 0.
- R7: On allocation the victim is the lowest-numbered invalid way of the set, or, if all ways are valid, the least recently trained way. Every accepted training, whether hit or allocation, makes its way the most recent. Lookups do not affect recency.
- R8: `predValid` and `predValue` are registered. They answer the lookup presented in the previous cycle, and `predValid` is 0 in any cycle after one with `lookupValid` low.
- R9: Lookups never modify the table. When a training and a lookup occur in the same cycle, the lookup sees the table as it was before that training.
- R10: `predValue` is 0 whenever `predValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| trainValid | input | 1 | A load retired in normal mode this cycle |
| trainPc | input | PC_W | PC of the retiring load |
| trainAddr | input | ADDR_W | Effective address of the retiring load |
| trainData | input | ADDR_W | Value returned by the retiring load |
| lookupValid | input | 1 | A load missed in L2 during runahead this cycle |
| lookupPc | input | PC_W | PC of the missing load |
| lookupAddr | input | ADDR_W | Effective address of the missing load |
| predValid | output | 1 | A confident prediction is available for the previous lookup |
| predValue | output | ADDR_W | Predicted loaded value, 0 when not valid |

## Verification
Training and lookup are independent ports, so an update and a prediction can fall in the same cycle. The bench provokes this by presenting a lookup for a PC whose confidence is one step below the threshold, in the same cycle as the training that raises it to the threshold. The answer to that lookup must be no prediction, because the lookup sees the table before the write. A lookup of the same PC in the following cycle must then predict the value derived from the new state.

// File: rtl/avd_pkg.sv
package avd_pkg;

  // Width of the way fields carried in the strobe bundle; caps ways at 16.
  localparam int WAY_FIELD_W = 4;

  typedef struct packed {
    logic                   trainWrite;  // an accepted training touches the table
    logic                   allocate;    // training misses: fill a fresh entry
    logic                   bumpConf;    // training hits with equal delta
    logic [WAY_FIELD_W-1:0] trainWay;    // way written by the training
    logic                   predFire;    // confident lookup hit
    logic [WAY_FIELD_W-1:0] predWay;     // way supplying the prediction
  } avdStrobes_t;

endpackage

// File: rtl/avd_datapath.sv
module avd_datapath
  import avd_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int NUM_SETS  = 8,
  parameter int NUM_WAYS  = 2,
  parameter int CONF_W    = 2,
  parameter int MAX_DELTA = 65536
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [PC_W-1:0]                     trainPc,
  input  logic [ADDR_W-1:0]                   trainAddr,
  input  logic [ADDR_W-1:0]                   trainData,
  input  logic [PC_W-1:0]                     lookupPc,
  input  logic [ADDR_W-1:0]                   lookupAddr,
  input  avdStrobes_t                         strobes,
  output logic                                deltaInRange,
  output logic [NUM_WAYS-1:0]                 trainHitVec,
  output logic [NUM_WAYS-1:0]                 trainMatchVec,
  output logic [NUM_WAYS-1:0]                 trainValidVec,
  output logic [NUM_WAYS-1:0][$clog2(NUM_WAYS)-1:0] trainAgeVec,
  output logic [NUM_WAYS-1:0]                 lookupHitVec,
  output logic [NUM_WAYS-1:0]                 lookupConfMaxVec,
  output logic                                predValid,
  output logic [ADDR_W-1:0]                   predValue
);

  localparam int IDX_W    = $clog2(NUM_SETS);
  localparam int TAG_W    = PC_W - IDX_W;
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic signed [ADDR_W-1:0] DELTA_POS = ADDR_W'(MAX_DELTA);
  localparam logic signed [ADDR_W-1:0] DELTA_NEG = -DELTA_POS;

  logic              entryValid [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0]  entryTag   [NUM_SETS][NUM_WAYS];
  logic [ADDR_W-1:0] entryDelta [NUM_SETS][NUM_WAYS];
  logic [CONF_W-1:0] entryConf  [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]  entryAge   [NUM_SETS][NUM_WAYS];

  logic [IDX_W-1:0]  trainIdx, lookupIdx;
  logic [TAG_W-1:0]  trainTag, lookupTag;
  logic signed [ADDR_W-1:0] newDelta;
  logic [WAY_W-1:0]  wrWay, rdWay;

  assign trainIdx  = trainPc[IDX_W-1:0];
  assign trainTag  = trainPc[PC_W-1:IDX_W];
  assign lookupIdx = lookupPc[IDX_W-1:0];
  assign lookupTag = lookupPc[PC_W-1:IDX_W];
  assign newDelta  = trainAddr - trainData;
  assign wrWay     = strobes.trainWay[WAY_W-1:0];
  assign rdWay     = strobes.predWay[WAY_W-1:0];

  assign deltaInRange = (newDelta <= DELTA_POS) && (newDelta >= DELTA_NEG);

  // Per-way read of both sets
  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_read
      assign trainValidVec[w]    = entryValid[trainIdx][w];
      assign trainHitVec[w]      = entryValid[trainIdx][w] && (entryTag[trainIdx][w] == trainTag);
      assign trainMatchVec[w]    = (entryDelta[trainIdx][w] == newDelta);
      assign trainAgeVec[w]      = entryAge[trainIdx][w];
      assign lookupHitVec[w]     = entryValid[lookupIdx][w] && (entryTag[lookupIdx][w] == lookupTag);
      assign lookupConfMaxVec[w] = (entryConf[lookupIdx][w] == CONF_MAX);
    end
  endgenerate

  // Table state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          entryValid[s][w] <= 1'b0;
          entryTag[s][w]   <= '0;
          entryDelta[s][w] <= '0;
          entryConf[s][w]  <= '0;
          entryAge[s][w]   <= WAY_W'(w);
        end
      end
    end else if (strobes.trainWrite) begin
      if (strobes.allocate) begin
        entryValid[trainIdx][wrWay] <= 1'b1;
        entryTag[trainIdx][wrWay]   <= trainTag;
        entryDelta[trainIdx][wrWay] <= newDelta;
        entryConf[trainIdx][wrWay]  <= '0;
      end else if (strobes.bumpConf) begin
        if (entryConf[trainIdx][wrWay] != CONF_MAX)
          entryConf[trainIdx][wrWay] <= entryConf[trainIdx][wrWay] + 1'b1;
      end else begin
        entryDelta[trainIdx][wrWay] <= newDelta;
        entryConf[trainIdx][wrWay]  <= '0;
      end
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == wrWay)
          entryAge[trainIdx][w] <= '0;
        else if (entryAge[trainIdx][w] < entryAge[trainIdx][wrWay])
          entryAge[trainIdx][w] <= entryAge[trainIdx][w] + 1'b1;
      end
    end
  end

  // Prediction register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predValue <= '0;
    end else begin
      predValid <= strobes.predFire;
      predValue <= strobes.predFire ? (lookupAddr - entryDelta[lookupIdx][rdWay]) : '0;
    end
  end

endmodule

// File: rtl/avd_control.sv
module avd_control
  import avd_pkg::*;
#(
  parameter int NUM_WAYS = 2
) (
  input  logic                                      trainValid,
  input  logic                                      lookupValid,
  input  logic                                      deltaInRange,
  input  logic [NUM_WAYS-1:0]                       trainHitVec,
  input  logic [NUM_WAYS-1:0]                       trainMatchVec,
  input  logic [NUM_WAYS-1:0]                       trainValidVec,
  input  logic [NUM_WAYS-1:0][$clog2(NUM_WAYS)-1:0] trainAgeVec,
  input  logic [NUM_WAYS-1:0]                       lookupHitVec,
  input  logic [NUM_WAYS-1:0]                       lookupConfMaxVec,
  output avdStrobes_t                               strobes
);

  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

  logic                   anyHit, hitMatch, freeFound, oldFound;
  logic [WAY_FIELD_W-1:0] hitWay, freeWay, oldWay, victimWay, lookWay;
  logic                   lookFound;

  always_comb begin
    anyHit    = 1'b0;
    hitMatch  = 1'b0;
    hitWay    = '0;
    freeFound = 1'b0;
    freeWay   = '0;
    oldFound  = 1'b0;
    oldWay    = '0;
    lookFound = 1'b0;
    lookWay   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (trainHitVec[w] && !anyHit) begin
        anyHit   = 1'b1;
        hitWay   = WAY_FIELD_W'(w);
        hitMatch = trainMatchVec[w];
      end
      if (!trainValidVec[w] && !freeFound) begin
        freeFound = 1'b1;
        freeWay   = WAY_FIELD_W'(w);
      end
      if ((trainAgeVec[w] == OLDEST) && !oldFound) begin
        oldFound = 1'b1;
        oldWay   = WAY_FIELD_W'(w);
      end
      if (lookupHitVec[w] && lookupConfMaxVec[w] && !lookFound) begin
        lookFound = 1'b1;
        lookWay   = WAY_FIELD_W'(w);
      end
    end
    victimWay = freeFound ? freeWay : oldWay;

    strobes.trainWrite = trainValid && deltaInRange;
    strobes.allocate   = !anyHit;
    strobes.bumpConf   = anyHit && hitMatch;
    strobes.trainWay   = anyHit ? hitWay : victimWay;
    strobes.predFire   = lookupValid && lookFound;
    strobes.predWay    = lookWay;
  end

endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
  import avd_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int NUM_SETS  = 8,
  parameter int NUM_WAYS  = 2,
  parameter int CONF_W    = 2,
  parameter int MAX_DELTA = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainValid,
  input  logic [PC_W-1:0]   trainPc,
  input  logic [ADDR_W-1:0] trainAddr,
  input  logic [ADDR_W-1:0] trainData,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              predValid,
  output logic [ADDR_W-1:0] predValue
);

  localparam int WAY_W = $clog2(NUM_WAYS);

  avdStrobes_t                   strobes;
  logic                          deltaInRange;
  logic [NUM_WAYS-1:0]           trainHitVec, trainMatchVec, trainValidVec;
  logic [NUM_WAYS-1:0][WAY_W-1:0] trainAgeVec;
  logic [NUM_WAYS-1:0]           lookupHitVec, lookupConfMaxVec;

  avd_control #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .trainValid      (trainValid),
    .lookupValid     (lookupValid),
    .deltaInRange    (deltaInRange),
    .trainHitVec     (trainHitVec),
    .trainMatchVec   (trainMatchVec),
    .trainValidVec   (trainValidVec),
    .trainAgeVec     (trainAgeVec),
    .lookupHitVec    (lookupHitVec),
    .lookupConfMaxVec(lookupConfMaxVec),
    .strobes         (strobes)
  );

  avd_datapath #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS), .CONF_W(CONF_W), .MAX_DELTA(MAX_DELTA)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .trainPc         (trainPc),
    .trainAddr       (trainAddr),
    .trainData       (trainData),
    .lookupPc        (lookupPc),
    .lookupAddr      (lookupAddr),
    .strobes         (strobes),
    .deltaInRange    (deltaInRange),
    .trainHitVec     (trainHitVec),
    .trainMatchVec   (trainMatchVec),
    .trainValidVec   (trainValidVec),
    .trainAgeVec     (trainAgeVec),
    .lookupHitVec    (lookupHitVec),
    .lookupConfMaxVec(lookupConfMaxVec),
    .predValid       (predValid),
    .predValue       (predValue)
  );

endmodule

// File: rtl/avd_predictor_chk.sv
module avd_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trainValid,
  input logic              lookupValid,
  input logic [PC_W-1:0]   lookupPc,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              predValid,
  input logic [ADDR_W-1:0] predValue
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!predValid && predValue == '0));

  // R8
  answer_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);

  // R10
  idle_value_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> (predValue == '0));

  // R9
  lookup_no_side_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && $past(lookupValid) && !$past(trainValid) && lookupPc == $past(lookupPc))
    |=> (predValid == $past(predValid)));

  // R2
  value_tracks_address_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && $past(lookupValid) && !$past(trainValid) && lookupPc == $past(lookupPc) && $past(predValid))
    |=> (!predValid || (ADDR_W'(predValue - $past(predValue)) == ADDR_W'($past(lookupAddr) - $past(lookupAddr, 2)))));

endmodule

bind avd_predictor avd_predictor_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/avd_predictor_tb.sv
module avd_predictor_tb;

  localparam int  CLK_PERIOD = 10;
  localparam int  PC_W = 32;
  localparam int  ADDR_W = 32;
  localparam int  WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              trainValid = 1'b0;
  logic [PC_W-1:0]   trainPc = '0;
  logic [ADDR_W-1:0] trainAddr = '0, trainData = '0;
  logic              lookupValid = 1'b0;
  logic [PC_W-1:0]   lookupPc = '0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic              predValid;
  logic [ADDR_W-1:0] predValue;

  int checks = 0;
  int fails = 0;
  bit sampledLookup = 1'b0;
  bit doneFlag = 1'b0;

  logic              expValidQ [$];
  logic [ADDR_W-1:0] expValueQ [$];
  string             expReqQ   [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  avd_predictor u_dut (
    .clk(clk), .rstN(rstN),
    .trainValid(trainValid), .trainPc(trainPc), .trainAddr(trainAddr), .trainData(trainData),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupAddr(lookupAddr),
    .predValid(predValid), .predValue(predValue)
  );

  task automatic check(input string req, input logic [ADDR_W:0] act, input logic [ADDR_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares each registered answer with the scoreboard front
  always @(posedge clk) sampledLookup <= lookupValid;

  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      if (sampledLookup) begin
        if (expValidQ.size() == 0) begin
          check("R8 unexpected answer", 1, 0);
        end else begin
          logic v; logic [ADDR_W-1:0] val; string r;
          v = expValidQ.pop_front(); val = expValueQ.pop_front(); r = expReqQ.pop_front();
          check(r, {predValid, predValue}, {v, val});
        end
      end else if (predValid) begin
        check("R8 idle valid", {predValid, predValue}, '0);
      end
    end
  end

  // Driver tasks (drive on negedge, hold one cycle)
  task automatic train(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr, input logic [ADDR_W-1:0] data);
    trainValid = 1'b1; trainPc = pc; trainAddr = addr; trainData = data;
    @(negedge clk);
    trainValid = 1'b0;
  endtask

  task automatic trainN(input int n, input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr, input logic [ADDR_W-1:0] data);
    for (int i = 0; i < n; i++) train(pc, addr, data);
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr,
                        input logic v, input logic [ADDR_W-1:0] val, input string req);
    lookupValid = 1'b1; lookupPc = pc; lookupAddr = addr;
    expValidQ.push_back(v); expValueQ.push_back(v ? val : '0); expReqQ.push_back(req);
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic both(input logic [PC_W-1:0] tpc, input logic [ADDR_W-1:0] taddr, input logic [ADDR_W-1:0] tdata,
                      input logic [PC_W-1:0] lpc, input logic [ADDR_W-1:0] laddr,
                      input logic v, input logic [ADDR_W-1:0] val, input string req);
    trainValid = 1'b1; trainPc = tpc; trainAddr = taddr; trainData = tdata;
    lookupValid = 1'b1; lookupPc = lpc; lookupAddr = laddr;
    expValidQ.push_back(v); expValueQ.push_back(v ? val : '0); expReqQ.push_back(req);
    @(negedge clk);
    trainValid = 1'b0; lookupValid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {predValid, predValue}, '0);
        rstN = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset", {predValid, predValue}, '0);
        lookup(32'h10, 32'h5000, 0, 0, "R1 empty table");

        // R5: three trainings not enough, fourth enables; R2 value
        trainN(3, 32'h10, 32'h1000, 32'h0F00);
        lookup(32'h10, 32'h5000, 0, 0, "R5 confidence below 3");
        train(32'h10, 32'h1000, 32'h0F00);
        lookup(32'h10, 32'h5000, 1, 32'h4F00, "R5 R2 confident prediction");
        train(32'h10, 32'h2000, 32'h1F00);
        lookup(32'h10, 32'h6000, 1, 32'h5F00, "R5 saturation keeps prediction");

        // R6: mismatch clears confidence and stores new delta
        train(32'h10, 32'h3000, 32'h2E00);
        lookup(32'h10, 32'h6000, 0, 0, "R6 mismatch clears confidence");
        trainN(3, 32'h10, 32'h3000, 32'h2E00);
        lookup(32'h10, 32'h6000, 1, 32'h5E00, "R6 new delta used");

        // R3: bounds inclusive, outside ignored
        trainN(4, 32'h21, 32'h0002_0000, 32'h0001_0000);
        lookup(32'h21, 32'h100, 1, 32'hFFFF_0100, "R3 upper bound accepted");
        trainN(4, 32'h22, 32'h0001_0000, 32'h0002_0000);
        lookup(32'h22, 32'h100, 1, 32'h0001_0100, "R3 lower bound accepted");
        trainN(4, 32'h23, 32'h0002_0001, 32'h0001_0000);
        lookup(32'h23, 32'h100, 0, 0, "R3 delta above bound ignored");
        trainN(4, 32'h24, 32'h0001_0000, 32'h0002_0001);
        lookup(32'h24, 32'h100, 0, 0, "R3 delta below bound ignored");
        train(32'h21, 32'h7FFF_FFFF, 32'h0);
        lookup(32'h21, 32'h200, 1, 32'hFFFF_0200, "R3 out-of-range leaves entry intact");

        // R4 / R7: two ways of set 5, LRU eviction, lookup does not refresh
        trainN(4, 32'h05, 32'h108, 32'h100);
        trainN(4, 32'h0D, 32'h110, 32'h100);
        lookup(32'h05, 32'h900, 1, 32'h8F8, "R4 way A held");
        lookup(32'h0D, 32'h900, 1, 32'h8F0, "R4 way B held");
        train(32'h05, 32'h108, 32'h100);
        lookup(32'h0D, 32'h900, 1, 32'h8F0, "R7 lookup before eviction");
        train(32'h15, 32'h120, 32'h100);
        lookup(32'h0D, 32'h900, 0, 0, "R7 least recent way evicted");
        lookup(32'h05, 32'hA00, 1, 32'h9F8, "R7 recent way kept");

        // R9: training and lookup in the same cycle
        trainN(3, 32'h16, 32'h440, 32'h400);
        both(32'h16, 32'h440, 32'h400, 32'h16, 32'h1000, 0, 0, "R9 same-cycle lookup sees old table");
        lookup(32'h16, 32'h1000, 1, 32'h0FC0, "R9 next lookup sees update");

        // R10 / R8: unknown PC gives zero value
        lookup(32'h37, 32'h1234, 0, 0, "R10 miss gives zero value");
        repeat (2) @(negedge clk);
        check("R8 scoreboard drained", expValidQ.size(), 0);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule